// File: doc/BRIEF.md
# Barrel-Scheduled Multithreaded Peripheral Processor

This block has one execution slot that is shared by `NCTX` small processor contexts. The contexts take turns in a fixed cyclic order. While `run` is high, each clock edge carries out one instruction for the context that holds the current slot and then passes the slot to the next context. Every context has its own program counter, an 18-bit accumulator, a halt flag and a private memory of 12-bit words. From the inside, each context is a plain in-order machine. Seen from the whole block, two consecutive instructions of one context are `NCTX` cycles apart.

Programs are written into the private memories through a valid/ready load stream, and only while `run` is low. `ld_ready` is the inverse of `run`. A word is written on a clock edge where `ld_valid` and `ld_ready` are both high. When `ld_ready` is low the producer must keep its word, and anything offered in that state is dropped. A combinational debug port reads back the program counter, accumulator and halt flag of the context chosen by `dbg_ctx`. `NCTX` may be 10, 14, 17 or 20. `MEM_AW` sets the private memory depth: 12 gives 4096 words per context, and the default of 8 keeps elaboration small.

An instruction word carries the opcode in bits 11:6 and an operand in bits 5:0. A long jump reads its target from the word that follows the opcode.

Top module: `bpp_barrel`

## Requirements
- R1: While `run` is high, `slot_ctx` advances by exactly one on every clock edge and wraps from NCTX-1 to 0. A halted context still holds its slot, so no context is ever skipped.
- R2: While `run` is low, no instruction executes, `slot_ctx` holds its value, and no context's pc, accumulator or halt flag changes.
- R3: After reset, `slot_ctx` is 0, context 0 executes first, and every context has pc 0, accumulator 0 and halt clear. Every memory word reads 0, which decodes as halt.
- R4: Opcode 0x01 loads the zero-extended operand into the accumulator. Opcode 0x02 adds the zero-extended operand to the accumulator modulo 2^18. Both advance pc by one.
- R5: Opcode 0x03 loads the zero-extended memory word at address = operand. Opcode 0x05 adds that word to the accumulator. Opcode 0x04 stores accumulator bits 11:0 at address = operand. All three advance pc by one.
- R6: Opcode 0x06 jumps to the operand when the accumulator is zero. Opcode 0x07 jumps to the operand when it is nonzero. If the jump is not taken, pc advances by one.
- R7: Opcode 0x08 sets pc to the low MEM_AW bits of the word at pc+1.
- R8: Opcode 0x00 sets the halt flag and leaves pc unchanged. A halted context changes no state until reset.
- R9: Opcodes 0x09 to 0x3F change nothing but pc, which advances by one.
- R10: `ld_ready` equals the inverse of `run`. An accepted load writes `ld_data` at `ld_addr` of context `ld_ctx`. A load offered while `run` is high is ignored.
- R11: The result of a slot is visible on the debug port right after that slot's clock edge, and the same context uses it on its next turn.
- R12: A `dbg_ctx` value of NCTX or above reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables execution and rotation |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load word accepted on this edge |
| ld_ctx | input | $clog2(NCTX) | Target context of the load |
| ld_addr | input | MEM_AW | Target word address |
| ld_data | input | 12 | Word to write |
| slot_ctx | output | $clog2(NCTX) | Context that owns the current slot |
| dbg_ctx | input | $clog2(NCTX) | Context selected for readback |
| dbg_pc | output | MEM_AW | Selected context's pc |
| dbg_acc | output | 18 | Selected context's accumulator |
| dbg_halt | output | 1 | Selected context's halt flag |

## Verification
Each executed instruction updates its context one clock edge after `slot_ctx` points at that context, and the debug port then shows the change combinationally. `slot_ctx` likewise changes one edge after `run` is seen high. The bench drives inputs on falling edges and samples on the next falling edge, so a single rising edge always lies between stimulus and check. A one-cycle pulse of `run` isolates the first slot, and the final state of every context is compared only after rotation has stopped. Ignored loads are offered just before the target context's first turn, and their absence shows up in that context's halt state.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
  localparam int WORD_W = 12;
  localparam int OP_W   = 6;
  localparam int FLD_W  = 6;
  localparam int ACC_W  = 18;

  localparam logic [OP_W-1:0] OP_HALT = 6'h00;
  localparam logic [OP_W-1:0] OP_LDI  = 6'h01;
  localparam logic [OP_W-1:0] OP_ADI  = 6'h02;
  localparam logic [OP_W-1:0] OP_LDM  = 6'h03;
  localparam logic [OP_W-1:0] OP_STM  = 6'h04;
  localparam logic [OP_W-1:0] OP_ADM  = 6'h05;
  localparam logic [OP_W-1:0] OP_JZ   = 6'h06;
  localparam logic [OP_W-1:0] OP_JNZ  = 6'h07;
  localparam logic [OP_W-1:0] OP_LJMP = 6'h08;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [FLD_W-1:0] fld;
  } insn_t;
endpackage

// File: rtl/bpp_rotor.sv
module bpp_rotor #(
  parameter int NCTX = 10,
  parameter int CW   = $clog2(NCTX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [CW-1:0] ctx
);
  localparam logic [CW-1:0] LAST = CW'(NCTX - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctx <= '0;
    else if (adv)    ctx <= (ctx == LAST) ? '0 : ctx + 1'b1;
  end
endmodule

// File: rtl/bpp_ctx_state.sv
module bpp_ctx_state #(
  parameter int NCTX  = 10,
  parameter int CW    = $clog2(NCTX),
  parameter int AW    = 8,
  parameter int ACC_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CW-1:0]    wctx,
  input  logic [AW-1:0]    wpc,
  input  logic [ACC_W-1:0] wacc,
  input  logic             whalt,
  input  logic [CW-1:0]    rctx,
  output logic [AW-1:0]    rpc,
  output logic [ACC_W-1:0] racc,
  output logic             rhalt,
  input  logic [CW-1:0]    dctx,
  output logic [AW-1:0]    dpc,
  output logic [ACC_W-1:0] dacc,
  output logic             dhalt
);
  logic [AW-1:0]    pc_q   [NCTX];
  logic [ACC_W-1:0] acc_q  [NCTX];
  logic             halt_q [NCTX];

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q[i]   <= '0;
        acc_q[i]  <= '0;
        halt_q[i] <= 1'b0;
      end else if (we && wctx == CW'(i)) begin
        pc_q[i]   <= wpc;
        acc_q[i]  <= wacc;
        halt_q[i] <= whalt;
      end
    end
  end

  // Execution-side read of the slot owner
  always_comb begin
    rpc = '0; racc = '0; rhalt = 1'b0;
    for (int i = 0; i < NCTX; i++) begin
      if (rctx == CW'(i)) begin
        rpc = pc_q[i]; racc = acc_q[i]; rhalt = halt_q[i];
      end
    end
  end

  // Debug read; unmatched selects give zeros
  always_comb begin
    dpc = '0; dacc = '0; dhalt = 1'b0;
    for (int i = 0; i < NCTX; i++) begin
      if (dctx == CW'(i)) begin
        dpc = pc_q[i]; dacc = acc_q[i]; dhalt = halt_q[i];
      end
    end
  end
endmodule

// File: rtl/bpp_pmem.sv
module bpp_pmem #(
  parameter int NCTX = 10,
  parameter int CW   = $clog2(NCTX),
  parameter int AW   = 8,
  parameter int DW   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wctx,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] rctx,
  input  logic [AW-1:0] ra_ins,
  input  logic [AW-1:0] ra_ext,
  input  logic [AW-1:0] ra_dat,
  output logic [DW-1:0] rd_ins,
  output logic [DW-1:0] rd_ext,
  output logic [DW-1:0] rd_dat
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ins_v [NCTX];
  logic [DW-1:0] ext_v [NCTX];
  logic [DW-1:0] dat_v [NCTX];

  for (genvar i = 0; i < NCTX; i++) begin : g_bank
    logic [DW-1:0] m [DEPTH];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int a = 0; a < DEPTH; a++) m[a] <= '0;
      end else if (we && wctx == CW'(i)) begin
        m[waddr] <= wdata;
      end
    end
    assign ins_v[i] = m[ra_ins];
    assign ext_v[i] = m[ra_ext];
    assign dat_v[i] = m[ra_dat];
  end

  always_comb begin
    rd_ins = '0; rd_ext = '0; rd_dat = '0;
    for (int i = 0; i < NCTX; i++) begin
      if (rctx == CW'(i)) begin
        rd_ins = ins_v[i]; rd_ext = ext_v[i]; rd_dat = dat_v[i];
      end
    end
  end
endmodule

// File: rtl/bpp_exec.sv
module bpp_exec
  import bpp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0]     pc,
  input  logic [ACC_W-1:0]  acc,
  input  logic              halt,
  input  logic [WORD_W-1:0] ins,
  input  logic [WORD_W-1:0] ext,
  input  logic [WORD_W-1:0] mdat,
  output logic [AW-1:0]     npc,
  output logic [ACC_W-1:0]  nacc,
  output logic              nhalt,
  output logic              st_en,
  output logic [AW-1:0]     st_addr,
  output logic [WORD_W-1:0] st_data
);
  insn_t i_w;
  assign i_w     = insn_t'(ins);
  assign st_addr = AW'(i_w.fld);
  assign st_data = acc[WORD_W-1:0];

  always_comb begin
    npc   = pc + 1'b1;
    nacc  = acc;
    nhalt = halt;
    st_en = 1'b0;
    if (halt) begin
      npc = pc;
    end else begin
      case (i_w.op)
        OP_HALT: begin npc = pc; nhalt = 1'b1; end
        OP_LDI:  nacc = ACC_W'(i_w.fld);
        OP_ADI:  nacc = acc + ACC_W'(i_w.fld);
        OP_LDM:  nacc = ACC_W'(mdat);
        OP_ADM:  nacc = acc + ACC_W'(mdat);
        OP_STM:  st_en = 1'b1;
        OP_JZ:   if (acc == '0) npc = AW'(i_w.fld);
        OP_JNZ:  if (acc != '0) npc = AW'(i_w.fld);
        OP_LJMP: npc = AW'(ext);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bpp_barrel.sv
module bpp_barrel
  import bpp_pkg::*;
#(
  parameter int NCTX   = 10,
  parameter int MEM_AW = 8,
  parameter int CW     = $clog2(NCTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [CW-1:0]     ld_ctx,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  output logic [CW-1:0]     slot_ctx,
  input  logic [CW-1:0]     dbg_ctx,
  output logic [MEM_AW-1:0] dbg_pc,
  output logic [ACC_W-1:0]  dbg_acc,
  output logic              dbg_halt
);
  if (!(NCTX == 10 || NCTX == 14 || NCTX == 17 || NCTX == 20)) begin : g_bad_nctx
    $error("NCTX must be 10, 14, 17 or 20");
  end
  if (MEM_AW < FLD_W || MEM_AW > WORD_W) begin : g_bad_aw
    $error("MEM_AW must lie between 6 and 12");
  end

  logic [CW-1:0]     cur;
  logic [MEM_AW-1:0] pc, npc, st_addr, mw_addr;
  logic [ACC_W-1:0]  acc, nacc;
  logic              halt, nhalt, st_en, ld_fire, mw_en;
  logic [WORD_W-1:0] ins, ext, mdat, st_data, mw_data;
  logic [CW-1:0]     mw_ctx;

  assign ld_ready = ~run;
  assign ld_fire  = ld_valid & ld_ready;
  assign slot_ctx = cur;

  assign mw_en   = ld_fire | (run & st_en);
  assign mw_ctx  = run ? cur     : ld_ctx;
  assign mw_addr = run ? st_addr : ld_addr;
  assign mw_data = run ? st_data : ld_data;

  bpp_rotor #(.NCTX(NCTX), .CW(CW)) u_rotor (
    .clk(clk), .rst_n(rst_n), .adv(run), .ctx(cur)
  );

  bpp_ctx_state #(.NCTX(NCTX), .CW(CW), .AW(MEM_AW), .ACC_W(ACC_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .we(run), .wctx(cur), .wpc(npc), .wacc(nacc), .whalt(nhalt),
    .rctx(cur), .rpc(pc), .racc(acc), .rhalt(halt),
    .dctx(dbg_ctx), .dpc(dbg_pc), .dacc(dbg_acc), .dhalt(dbg_halt)
  );

  bpp_pmem #(.NCTX(NCTX), .CW(CW), .AW(MEM_AW), .DW(WORD_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(mw_en), .wctx(mw_ctx), .waddr(mw_addr), .wdata(mw_data),
    .rctx(cur), .ra_ins(pc), .ra_ext(pc + 1'b1),
    .ra_dat(MEM_AW'(ins[FLD_W-1:0])),
    .rd_ins(ins), .rd_ext(ext), .rd_dat(mdat)
  );

  bpp_exec #(.AW(MEM_AW)) u_exec (
    .pc(pc), .acc(acc), .halt(halt),
    .ins(ins), .ext(ext), .mdat(mdat),
    .npc(npc), .nacc(nacc), .nhalt(nhalt),
    .st_en(st_en), .st_addr(st_addr), .st_data(st_data)
  );
endmodule

// File: rtl/bpp_barrel_chk.sv
module bpp_barrel_chk #(
  parameter int NCTX = 10,
  parameter int CW   = $clog2(NCTX),
  parameter int AW   = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [CW-1:0] slot_ctx,
  input logic [CW-1:0] dbg_ctx,
  input logic [AW-1:0] dbg_pc,
  input logic [17:0]   dbg_acc,
  input logic          dbg_halt
);
  // R1
  rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> slot_ctx == (($past(slot_ctx) == CW'(NCTX - 1)) ? CW'(0) : $past(slot_ctx) + 1'b1));

  // R1
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_ctx) < NCTX);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(slot_ctx));

  // R2
  idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!$stable(dbg_ctx) || ($stable(dbg_pc) && $stable(dbg_acc) && $stable(dbg_halt))));

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt |=> (!$stable(dbg_ctx) || (dbg_halt && $stable(dbg_pc) && $stable(dbg_acc))));
endmodule

bind bpp_barrel bpp_barrel_chk #(.NCTX(NCTX), .CW(CW), .AW(MEM_AW)) u_chk (.*);

// File: tb/sim_bpp_barrel.sv
`timescale 1ns/1ps
module sim_bpp_barrel;
  localparam int NC = 10;
  localparam int AW = 8;
  localparam int CW = $clog2(NC);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [CW-1:0] ld_ctx = '0;
  logic [AW-1:0] ld_addr = '0;
  logic [11:0]   ld_data = '0;
  logic [CW-1:0] slot_ctx;
  logic [CW-1:0] dbg_ctx = '0;
  logic [AW-1:0] dbg_pc;
  logic [17:0]   dbg_acc;
  logic          dbg_halt;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  bpp_barrel #(.NCTX(NC), .MEM_AW(AW)) u0 (.*);

  // Load vectors: [31:24] ctx, [23:16] addr, [11:0] word
  localparam int NLD = 25;
  localparam logic [31:0] LD [NLD] = '{
    32'h0000_0045, 32'h0001_0087,                               // ctx0 R4
    32'h0100_007F, 32'h0101_0128, 32'h0102_0168,                // ctx1 R5
    32'h0200_0042, 32'h0201_01C4, 32'h0202_0049, 32'h0204_0081, // ctx2 R6
    32'h0300_0183, 32'h0301_0041, 32'h0303_0200, 32'h0304_0020,
    32'h0320_0051,                                              // ctx3 R7
    32'h0400_00F2, 32'h0401_0172, 32'h0402_0133, 32'h0403_00F3,
    32'h0432_0FFF,                                              // ctx4 R5
    32'h0600_0FC0, 32'h0601_0041,                               // ctx6 R9
    32'h0700_01C5, 32'h0701_0042, 32'h0702_0186,                // ctx7 R6
    32'h0900_0044                                               // ctx9 R1
  };

  // Expected final state: [47:40] ctx, [39:32] pc, [31:24] halt, [23:0] acc
  localparam logic [47:0] EX [NC] = '{
    48'h00_02_01_00000C, 48'h01_03_01_00007E, 48'h02_05_01_000003,
    48'h03_21_01_000011, 48'h04_04_01_000FFE, 48'h05_00_01_000000,
    48'h06_02_01_000001, 48'h07_03_01_000002, 48'h08_00_01_000000,
    48'h09_01_01_000004
  };

  function automatic string req_of(int c);
    case (c)
      0: return "R4/R11";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R5";
      5: return "R3/R8";
      6: return "R9";
      7: return "R6";
      8: return "R10";
      default: return "R1/R8";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic peek(int c);
    dbg_ctx = CW'(c);
    #0.5;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: reset state
    chk("R3 slot", 32'(slot_ctx), 0);
    chk("R10 ready idle", 32'(ld_ready), 1);
    for (int c = 0; c < NC; c++) begin
      peek(c);
      chk("R3 pc/acc/halt", {dbg_pc, dbg_acc, 6'(dbg_halt)}, 0);
    end
    // R12: out-of-range select
    peek(15);
    chk("R12", {dbg_pc, dbg_acc, 6'(dbg_halt)}, 0);

    // Load table walk (R10)
    for (int i = 0; i < NLD; i++) begin
      ld_valid = 1'b1;
      ld_ctx   = LD[i][27:24];
      ld_addr  = LD[i][23:16];
      ld_data  = LD[i][11:0];
      @(negedge clk);
    end
    ld_valid = 1'b0;

    // R11: single slot, result visible right after its edge
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    peek(0);
    chk("R11 acc", 32'(dbg_acc), 5);
    chk("R11 pc", 32'(dbg_pc), 1);
    chk("R1 first step", 32'(slot_ctx), 1);
    peek(1);
    chk("R2 ctx1 untouched", 32'(dbg_pc), 0);

    // R2: idle holds everything
    repeat (3) @(negedge clk);
    chk("R2 slot hold", 32'(slot_ctx), 1);
    peek(0);
    chk("R2 acc hold", 32'(dbg_acc), 5);

    // Run with a load offered to ctx8 before its first turn (R10)
    run      = 1'b1;
    ld_valid = 1'b1;
    ld_ctx   = CW'(8);
    ld_addr  = '0;
    ld_data  = 12'h049;
    #0.5;
    chk("R10 ready busy", 32'(ld_ready), 0);
    begin
      int e = 1;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        e = (e + 1) % NC;
        chk("R1 rotation", 32'(slot_ctx), 32'(e));
      end
    end
    run      = 1'b0;
    ld_valid = 1'b0;
    @(negedge clk);
    chk("R1 wrap count", 32'(slot_ctx), 1);

    // Final state table
    for (int i = 0; i < NC; i++) begin
      peek(int'(EX[i][47:40]));
      chk(req_of(i), 32'(dbg_pc), 32'(EX[i][39:32]));
      chk(req_of(i), 32'(dbg_acc), 32'(EX[i][23:0]));
      chk(req_of(i), 32'(dbg_halt), 32'(EX[i][31:24]));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule